// File: doc/BRIEF.md
# Write-Miss Controller with One-Line Eviction Buffer

This block services data-cache write misses. When a miss arrives, the caller has already compared tags and picked the victim way. The block then decides how the victim is handled. In write-back mode a dirty victim is first copied, one word per cycle, into a buffer that holds one line. The new line is then fetched from memory, and the store data is merged into that line as it is written into the data array. Finally the tag entry is marked valid and dirty, and the refilled way is reported as most recently used. In write-through mode the miss becomes a single memory write, and the cache is left as it was.

The buffered victim is written back to memory in the background, one word per memory handshake. A new miss can take the memory port between two drain beats, so fills go ahead of write-back traffic. Cache lookups keep running during the drain. The block only flags a lookup when it targets the line held in the buffer. It also holds back any miss that would need the buffer while the buffer is occupied, and any miss that targets the buffered line.

Top module: `wbMissBuffer`

## Requirements
- R1: A dirty write-back miss reads victim words through `vicRdEn`/`vicRdWord` in order 0, 1, 2, 3, one per cycle. All four reads happen before the first fill request. The buffer keeps the four 32-bit words and the victim line address `victimLine` (address bits 31..4).
- R2: Each drain write drives `memAddr = {3'b000, line[28:4], word[1:0], 2'b00}`. Here `line` is the buffered line address, so the top three address bits are always zero.
- R3: The drain writes words 0, 1, 2, 3 in ascending order, one per acknowledged handshake, and each carries the captured victim word. After the fourth acknowledge the buffer is empty, and `lkStall` no longer asserts for that line.
- R4: No drain write of a victim occurs before all four fill reads of the miss that evicted it have been acknowledged.
- R5: A write-back fill issues four reads to `{reqAddr[31:4], word, 2'b00}` with words ascending. Each acknowledge writes that word to the array, using the way `reqWay` and line `reqAddr[31:4]`. The word selected by `reqAddr[3:2]` receives `reqData` in place of the memory data. On the last acknowledge, `tagWrEn` (set valid and dirty), `lruTouch` and `reqDone` are asserted.
- R6: A write-through miss makes exactly one memory write of `reqData` to `{reqAddr[31:2], 2'b00}`, with `reqDone` on its acknowledge. It causes no array write, no tag write, no victim read and no fill, whatever `victimDirty` says.
- R7: A write-back miss whose victim is clean does no victim read and adds nothing to the drain.
- R8: A dirty write-back miss that arrives while the buffer is occupied waits. Its victim reads start only after the last drain beat is acknowledged.
- R9: `lkStall` is high exactly when `lkValid` is set, the buffer is occupied and `lkLine` equals the buffered line. A miss whose line equals the buffered line is not started until the buffer is empty.
- R10: A memory request is held with stable address, direction and data until `memAck`. A waiting miss is accepted in preference to starting the next drain beat, so its fill runs before the remaining drain beats.
- R11: During and right after reset, with no request pending, `memReq`, `vicRdEn`, `arrWrEn`, `tagWrEn`, `reqDone` and `lkStall` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wbMode | input | 1 | 1 = write-back, 0 = write-through |
| reqValid | input | 1 | Write miss pending; held until `reqDone` |
| reqAddr | input | 32 | Byte address of the missing store |
| reqData | input | 32 | Store data |
| reqWay | input | 2 | Way chosen for refill |
| victimDirty | input | 1 | Dirty bit of the victim entry |
| victimLine | input | 28 | Line address (bits 31..4) of the victim |
| reqDone | output | 1 | Miss completed this cycle |
| vicRdEn | output | 1 | Victim word read strobe |
| vicRdWord | output | 2 | Victim word index |
| vicRdData | input | 32 | Victim word, same-cycle read data |
| arrWay | output | 2 | Way addressed in the data array |
| arrLine | output | 28 | Line addressed in the data array |
| arrWrEn | output | 1 | Data array word write |
| arrWrWord | output | 2 | Word index written |
| arrWrData | output | 32 | Word data written (merged) |
| tagWrEn | output | 1 | Tag entry update: set valid and dirty |
| lruTouch | output | 1 | Mark `arrWay` most recently used |
| lkValid | input | 1 | A cache lookup is in progress |
| lkLine | input | 28 | Line address of the lookup |
| lkStall | output | 1 | Lookup hits the buffered line; retry |
| memReq | output | 1 | Memory beat request |
| memWrite | output | 1 | Beat direction, 1 = write |
| memAddr | output | 32 | Beat word address |
| memWData | output | 32 | Beat write data |
| memAck | input | 1 | Beat accepted/completed this cycle |
| memRData | input | 32 | Read data, valid with `memAck` |

## Verification
The hardest situation to reach is a new miss arriving while an older victim is still halfway through its drain. That is where fill priority, the full-buffer stall and the same-line stall all apply. The stimulus reaches it by giving back-to-back misses to a memory model whose acknowledge delay is raised to several cycles, so the drain is still in progress when the next request shows up. The model tracks expected drain beats in a queue and flags any fill that overtakes a queued beat of its own line, and any victim read while beats are still pending.

// File: rtl/wbPkg.sv
package wbPkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_COPY,
    ST_FILL,
    ST_WTHRU
  } ctlState_t;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_FILL,
    SEL_WT,
    SEL_DRAIN
  } memSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic    latch;     // capture the accepted request
    logic    capWord;   // store victim word at beatIdx
    logic    capDone;   // last victim word: buffer becomes occupied
    logic    fillAck;   // a fill beat completed
    logic    drainAck;  // a drain beat completed
    memSel_t sel;       // owner of the memory port this cycle
  } ctlStrobe_t;

endpackage

// File: rtl/wbControl.sv
module wbControl
  import wbPkg::*;
#(
  parameter int LINE_WORDS = 4,
  localparam int IDX_W = $clog2(LINE_WORDS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             wbMode,
  input  logic             victimDirty,
  input  logic             reqBufMatch,
  input  logic             bufFull,
  input  logic             memAck,
  output ctlStrobe_t       st,
  output logic [IDX_W-1:0] beatIdx,
  output logic             vicRdEn,
  output logic             arrWrEn,
  output logic             tagWrEn,
  output logic             reqDone,
  output logic             memReq
);

  ctlState_t        state, stateNx;
  logic [IDX_W-1:0] cnt, cntNx;
  logic             drainOpen;
  logic             lastBeat, blockNew, accept, drainGo;
  memSel_t          sel;

  assign lastBeat = (cnt == IDX_W'(LINE_WORDS - 1));

  // a miss waits while a drain beat is open, while it targets the
  // buffered line, or while it needs the buffer and the buffer is busy
  assign blockNew = drainOpen | reqBufMatch | (wbMode & victimDirty & bufFull);
  assign accept   = (state == ST_IDLE) & reqValid & ~blockNew;

  // drain beats only start when no miss is taking the port
  assign drainGo  = bufFull & (drainOpen | ((state == ST_IDLE) & ~accept));

  always_comb begin
    unique case (state)
      ST_FILL:  sel = SEL_FILL;
      ST_WTHRU: sel = SEL_WT;
      default:  sel = drainGo ? SEL_DRAIN : SEL_NONE;
    endcase
  end

  always_comb begin
    stateNx = state;
    cntNx   = cnt;
    unique case (state)
      ST_IDLE: begin
        cntNx = '0;
        if (accept) begin
          if (!wbMode)          stateNx = ST_WTHRU;
          else if (victimDirty) stateNx = ST_COPY;
          else                  stateNx = ST_FILL;
        end
      end
      ST_COPY: begin
        cntNx = cnt + 1'b1;
        if (lastBeat) begin
          stateNx = ST_FILL;
          cntNx   = '0;
        end
      end
      ST_FILL: begin
        if (memAck) begin
          cntNx = cnt + 1'b1;
          if (lastBeat) stateNx = ST_IDLE;
        end
      end
      ST_WTHRU: begin
        if (memAck) stateNx = ST_IDLE;
      end
      default: stateNx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      drainOpen <= 1'b0;
    end else begin
      state     <= stateNx;
      cnt       <= cntNx;
      drainOpen <= (sel == SEL_DRAIN) & ~memAck;
    end
  end

  assign st.latch    = accept;
  assign st.capWord  = (state == ST_COPY);
  assign st.capDone  = (state == ST_COPY) & lastBeat;
  assign st.fillAck  = (state == ST_FILL) & memAck;
  assign st.drainAck = (sel == SEL_DRAIN) & memAck;
  assign st.sel      = sel;

  assign beatIdx = cnt;
  assign vicRdEn = (state == ST_COPY);
  assign arrWrEn = st.fillAck;
  assign tagWrEn = st.fillAck & lastBeat;
  assign reqDone = (st.fillAck & lastBeat) | ((state == ST_WTHRU) & memAck);
  assign memReq  = (sel != SEL_NONE);

endmodule

// File: rtl/wbDatapath.sv
module wbDatapath
  import wbPkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int WAY_W      = 2,
  parameter int ZERO_TOP   = 3,
  localparam int IDX_W  = $clog2(LINE_WORDS),
  localparam int BYTE_W = $clog2(DATA_W / 8),
  localparam int OFF_W  = IDX_W + BYTE_W,
  localparam int LINE_W = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        st,
  input  logic [IDX_W-1:0]  beatIdx,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic [WAY_W-1:0]  reqWay,
  input  logic [LINE_W-1:0] victimLine,
  input  logic [DATA_W-1:0] vicRdData,
  input  logic [DATA_W-1:0] memRData,
  input  logic              lkValid,
  input  logic [LINE_W-1:0] lkLine,
  output logic              bufFull,
  output logic              reqBufMatch,
  output logic              lkStall,
  output logic [WAY_W-1:0]  arrWay,
  output logic [LINE_W-1:0] arrLine,
  output logic [DATA_W-1:0] arrWrData,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWData
);

  logic [LINE_W-1:0] curLine, vicLine, bufLine;
  logic [IDX_W-1:0]  curWord, drainIdx;
  logic [DATA_W-1:0] curData;
  logic [WAY_W-1:0]  curWay;
  logic [DATA_W-1:0] bufRd [LINE_WORDS];
  logic              unusedLow;

  assign unusedLow = ^reqAddr[BYTE_W-1:0];

  // request context, captured when the miss is accepted
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curLine <= '0;
      curWord <= '0;
      curData <= '0;
      curWay  <= '0;
      vicLine <= '0;
    end else if (st.latch) begin
      curLine <= reqAddr[ADDR_W-1:OFF_W];
      curWord <= reqAddr[OFF_W-1:BYTE_W];
      curData <= reqData;
      curWay  <= reqWay;
      vicLine <= victimLine;
    end
  end

  // one register per buffered word
  for (genvar w = 0; w < LINE_WORDS; w++) begin : gWord
    logic [DATA_W-1:0] wordQ;
    always_ff @(posedge clk) begin
      if (st.capWord && beatIdx == IDX_W'(w)) wordQ <= vicRdData;
    end
    assign bufRd[w] = wordQ;
  end

  // occupancy, line address and drain pointer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufFull  <= 1'b0;
      bufLine  <= '0;
      drainIdx <= '0;
    end else if (st.capDone) begin
      bufFull  <= 1'b1;
      bufLine  <= vicLine;
      drainIdx <= '0;
    end else if (st.drainAck) begin
      drainIdx <= drainIdx + 1'b1;
      if (drainIdx == IDX_W'(LINE_WORDS - 1)) bufFull <= 1'b0;
    end
  end

  assign reqBufMatch = bufFull & (reqAddr[ADDR_W-1:OFF_W] == bufLine);
  assign lkStall     = lkValid & bufFull & (lkLine == bufLine);

  assign arrWay    = curWay;
  assign arrLine   = curLine;
  assign arrWrData = (beatIdx == curWord) ? curData : memRData;

  always_comb begin
    memWrite = 1'b0;
    memAddr  = '0;
    memWData = '0;
    unique case (st.sel)
      SEL_FILL: memAddr = {curLine, beatIdx, {BYTE_W{1'b0}}};
      SEL_WT: begin
        memWrite = 1'b1;
        memAddr  = {curLine, curWord, {BYTE_W{1'b0}}};
        memWData = curData;
      end
      SEL_DRAIN: begin
        memWrite = 1'b1;
        memAddr  = {{ZERO_TOP{1'b0}}, bufLine[LINE_W-ZERO_TOP-1:0], drainIdx, {BYTE_W{1'b0}}};
        memWData = bufRd[drainIdx];
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/wbMissBuffer.sv
module wbMissBuffer
  import wbPkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int WAYS       = 4,
  parameter int ZERO_TOP   = 3,
  localparam int WAY_W  = $clog2(WAYS),
  localparam int IDX_W  = $clog2(LINE_WORDS),
  localparam int BYTE_W = $clog2(DATA_W / 8),
  localparam int LINE_W = ADDR_W - IDX_W - BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wbMode,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic [WAY_W-1:0]  reqWay,
  input  logic              victimDirty,
  input  logic [LINE_W-1:0] victimLine,
  output logic              reqDone,
  output logic              vicRdEn,
  output logic [IDX_W-1:0]  vicRdWord,
  input  logic [DATA_W-1:0] vicRdData,
  output logic [WAY_W-1:0]  arrWay,
  output logic [LINE_W-1:0] arrLine,
  output logic              arrWrEn,
  output logic [IDX_W-1:0]  arrWrWord,
  output logic [DATA_W-1:0] arrWrData,
  output logic              tagWrEn,
  output logic              lruTouch,
  input  logic              lkValid,
  input  logic [LINE_W-1:0] lkLine,
  output logic              lkStall,
  output logic              memReq,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWData,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memRData
);

  ctlStrobe_t       st;
  memSel_t          memSel;
  logic [IDX_W-1:0] beatIdx;
  logic             bufFull, reqBufMatch;

  wbControl #(.LINE_WORDS(LINE_WORDS)) uCtl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .wbMode(wbMode),
    .victimDirty(victimDirty), .reqBufMatch(reqBufMatch), .bufFull(bufFull),
    .memAck(memAck), .st(st), .beatIdx(beatIdx), .vicRdEn(vicRdEn),
    .arrWrEn(arrWrEn), .tagWrEn(tagWrEn), .reqDone(reqDone), .memReq(memReq)
  );

  wbDatapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS),
    .WAY_W(WAY_W), .ZERO_TOP(ZERO_TOP)
  ) uDp (
    .clk(clk), .rstN(rstN), .st(st), .beatIdx(beatIdx), .reqAddr(reqAddr),
    .reqData(reqData), .reqWay(reqWay), .victimLine(victimLine),
    .vicRdData(vicRdData), .memRData(memRData), .lkValid(lkValid),
    .lkLine(lkLine), .bufFull(bufFull), .reqBufMatch(reqBufMatch),
    .lkStall(lkStall), .arrWay(arrWay), .arrLine(arrLine),
    .arrWrData(arrWrData), .memWrite(memWrite), .memAddr(memAddr),
    .memWData(memWData)
  );

  assign memSel    = st.sel;
  assign vicRdWord = beatIdx;
  assign arrWrWord = beatIdx;
  assign lruTouch  = tagWrEn;

endmodule

// File: rtl/wbMissBufferChk.sv
module wbMissBufferChk
  import wbPkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int ZERO_TOP   = 3,
  localparam int IDX_W = $clog2(LINE_WORDS)
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReq,
  input logic              memAck,
  input logic              memWrite,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memWData,
  input logic              vicRdEn,
  input logic              arrWrEn,
  input logic [IDX_W-1:0]  arrWrWord,
  input logic              tagWrEn,
  input logic              reqDone,
  input logic              lkStall,
  input logic              bufFull,
  input memSel_t           memSel
);

  AST_DRAIN_TOP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memSel == SEL_DRAIN) |-> (memAddr[ADDR_W-1 -: ZERO_TOP] == '0)); // R2

  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWrite) && $stable(memWData))); // R10

  AST_WT_NO_ARRAY: assert property (@(posedge clk) disable iff (!rstN)
    (memSel == SEL_WT) |-> (!arrWrEn && !tagWrEn && !vicRdEn)); // R6

  AST_COPY_QUIET_PORT: assert property (@(posedge clk) disable iff (!rstN)
    vicRdEn |-> (!memReq && !bufFull)); // R8

  AST_TAG_LAST_WORD: assert property (@(posedge clk) disable iff (!rstN)
    tagWrEn |-> (arrWrEn && arrWrWord == IDX_W'(LINE_WORDS - 1))); // R5

  AST_DONE_ON_ACK: assert property (@(posedge clk) disable iff (!rstN)
    reqDone |-> memAck); // R5

  AST_STALL_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rstN)
    lkStall |-> bufFull); // R9

endmodule

bind wbMissBuffer wbMissBufferChk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS), .ZERO_TOP(ZERO_TOP)
) uChk (.*);

// File: tb/tb_wbMissBuffer.sv
module tb_wbMissBuffer;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32, DW = 32, LW = 28, WW = 2, IW = 2;

  logic clk = 1'b0, rstN = 1'b0;
  logic wbMode = 1'b1, reqValid = 1'b0, victimDirty = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqData = '0, vicRdData = '0, memRData = '0;
  logic [WW-1:0] reqWay = '0;
  logic [LW-1:0] victimLine = '0, lkLine = '0;
  logic lkValid = 1'b0, memAck = 1'b0;
  logic reqDone, vicRdEn, arrWrEn, tagWrEn, lruTouch, lkStall, memReq, memWrite;
  logic [IW-1:0] vicRdWord, arrWrWord;
  logic [WW-1:0] arrWay;
  logic [LW-1:0] arrLine;
  logic [DW-1:0] arrWrData, memWData;
  logic [AW-1:0] memAddr;

  wbMissBuffer dut (.*);

  always #(CLK_PERIOD / 2) clk = ~clk;

  int total = 0, bad = 0, cycles = 0, ackDelay = 0, waitCnt = 0;
  int fillIdx = 0, vicIdx = 0, fillWhileDrain = 0;
  bit curWb = 0, curDirty = 0, reqOpen = 0, doneSeen = 0;
  logic [LW-1:0] curLine = '0, curVic = '0;
  logic [IW-1:0] curWordIdx = '0;
  logic [DW-1:0] curData = '0;
  logic [WW-1:0] curWay = '0;
  logic [AW-1:0] drainAddrQ[$];
  logic [DW-1:0] drainDataQ[$];

  function automatic logic [DW-1:0] memWord(input logic [AW-1:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_1234;
  endfunction

  function automatic logic [DW-1:0] vicWord(input logic [LW-1:0] l, input logic [IW-1:0] w);
    return {l[15:0], 14'h0, w} ^ 32'h0F0F_0000;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic finishReq();
    if (curWb && curDirty)
      for (int w = 0; w < 4; w++) begin
        drainAddrQ.push_back({3'b000, curVic[24:0], w[1:0], 2'b00});
        drainDataQ.push_back(vicWord(curVic, w[1:0]));
      end
    reqOpen = 0;
    doneSeen = 1;
  endtask

  // reference model: compared on every clock
  task automatic monitor();
    logic [AW-1:0] ea;
    logic [DW-1:0] ed;
    bit last, sameLine;
    if (vicRdEn) begin
      chk(reqOpen && curDirty && curWb, "R7", "victim read only for dirty write-back miss", 32'(vicRdEn), 0);
      chk(vicRdWord == vicIdx[1:0], "R1", "victim word order", 32'(vicRdWord), vicIdx);
      chk(drainAddrQ.size() == 0, "R8", "victim read while buffer busy", drainAddrQ.size(), 0);
      vicIdx++;
    end
    if (memReq && memAck) begin
      if (!memWrite) begin
        ea = {curLine, fillIdx[1:0], 2'b00};
        chk(reqOpen && curWb, "R6", "fill read only in write-back mode", 32'(curWb), 1);
        chk(memAddr == ea, "R5", "fill address", memAddr, ea);
        if (curDirty) chk(vicIdx == 4, "R1", "victim copied before fill", vicIdx, 4);
        sameLine = 0;
        foreach (drainAddrQ[i]) if (drainAddrQ[i][28:4] == curLine[24:0]) sameLine = 1;
        chk(!sameLine, "R9", "fill of line still in buffer", 32'(sameLine), 0);
        if (drainAddrQ.size() > 0) fillWhileDrain++;
        ed = (fillIdx[1:0] == curWordIdx) ? curData : memWord(memAddr);
        chk(arrWrEn && arrWrWord == fillIdx[1:0] && arrWrData == ed && arrWay == curWay && arrLine == curLine,
            "R5", "merged array write", arrWrData, ed);
        last = (fillIdx == 3);
        chk(tagWrEn == last && lruTouch == last && reqDone == last, "R5", "tag/lru/done on last beat",
            {29'd0, tagWrEn, lruTouch, reqDone}, {29'd0, {3{last}}});
        fillIdx++;
        if (last) finishReq();
      end else if (reqOpen && !curWb && memAddr == {curLine, curWordIdx, 2'b00}) begin
        chk(memWData == curData, "R6", "write-through data", memWData, curData);
        chk(reqDone && !arrWrEn && !tagWrEn, "R6", "write-through strobes",
            {29'd0, reqDone, arrWrEn, tagWrEn}, 32'h4);
        finishReq();
      end else if (drainAddrQ.size() == 0) begin
        chk(0, "R4", "drain write before its fill finished", memAddr, 0);
      end else begin
        ea = drainAddrQ.pop_front();
        ed = drainDataQ.pop_front();
        chk(memAddr == ea, "R2", "drain address", memAddr, ea);
        chk(memWData == ed, "R3", "drain data", memWData, ed);
        chk(!arrWrEn && !reqDone, "R3", "drain beat has no array strobe", 32'(arrWrEn), 0);
      end
    end else if (arrWrEn || tagWrEn || reqDone) begin
      chk(0, "R5", "array strobe without fill ack", {29'd0, arrWrEn, tagWrEn, reqDone}, 0);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (memReq && !memAck) waitCnt++;
    else waitCnt = 0;
    if (cycles > 20000) begin
      bad++;
      total++;
      $display("FAIL R10 watchdog expired act=%0d exp=%0d", cycles, 20000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // memory and data-array models, then the comparison
  always begin
    @(negedge clk);
    #1;
    memAck = memReq && (waitCnt >= ackDelay);
    memRData = (memReq && !memWrite) ? memWord(memAddr) : '0;
    vicRdData = vicWord(curVic, vicRdWord);
    #1;
    if (rstN) monitor();
  end

  task automatic miss(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [WW-1:0] way,
                      input logic [LW-1:0] vic, input bit dirty, input bit wb);
    @(negedge clk);
    curLine = a[31:4]; curWordIdx = a[3:2]; curData = d; curWay = way;
    curVic = vic; curDirty = dirty; curWb = wb;
    fillIdx = 0; vicIdx = 0; doneSeen = 0; reqOpen = 1;
    reqAddr = a; reqData = d; reqWay = way; victimLine = vic;
    victimDirty = dirty; wbMode = wb; reqValid = 1'b1;
    while (!doneSeen) @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitDrained();
    while (drainAddrQ.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic lookup(input logic [LW-1:0] l, input bit exp, input string what);
    lkValid = 1'b1;
    lkLine = l;
    #2;
    chk(lkStall == exp, "R9", what, 32'(lkStall), 32'(exp));
    lkValid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk(!memReq && !vicRdEn && !arrWrEn && !tagWrEn && !reqDone && !lkStall, "R11", "outputs in reset",
        {26'd0, memReq, vicRdEn, arrWrEn, tagWrEn, reqDone, lkStall}, 0);
    @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    #2;
    chk(!memReq && !vicRdEn && !lkStall, "R11", "idle after reset", {29'd0, memReq, vicRdEn, lkStall}, 0);

    // R5 R7: clean victim, merged word 2
    miss(32'hC000_1238, 32'hDEAD_0001, 2'd1, 28'h111_2222, 1'b0, 1'b1);
    repeat (4) @(negedge clk);
    #2;
    chk(!memReq && drainAddrQ.size() == 0, "R7", "no drain after clean victim", 32'(memReq), 0);

    // R1 R2 R3 R4 R9: dirty victim with high address bits set, slow memory
    ackDelay = 2;
    miss(32'hE000_2004, 32'hBEEF_0002, 2'd2, 28'hABC_DEF1, 1'b1, 1'b1);
    lookup(28'hABC_DEF1, 1'b1, "lookup to buffered line stalls");
    lookup(28'hABC_DEF0, 1'b0, "lookup to other line proceeds");
    waitDrained();
    lookup(28'hABC_DEF1, 1'b0, "stall released after last drain beat (R3)");

    // R6: write-through miss ignores a dirty victim
    ackDelay = 1;
    miss(32'hD000_0108, 32'hCAFE_0003, 2'd0, 28'h333_4444, 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    #2;
    chk(!memReq && drainAddrQ.size() == 0, "R6", "write-through leaves buffer empty", 32'(memReq), 0);

    // R8: second dirty miss while buffer is occupied
    ackDelay = 3;
    miss(32'hC100_0000, 32'h0101_0101, 2'd3, 28'h055_6677, 1'b1, 1'b1);
    miss(32'hC200_000C, 32'h0202_0202, 2'd1, 28'h088_99AA, 1'b1, 1'b1);
    waitDrained();

    // R10: clean miss overtakes the rest of a slow drain
    ackDelay = 4;
    miss(32'hC300_0004, 32'h0303_0303, 2'd0, 28'h0BB_CCDD, 1'b1, 1'b1);
    fillWhileDrain = 0;
    miss(32'hC400_0008, 32'h0404_0404, 2'd2, 28'h0EE_FF00, 1'b0, 1'b1);
    chk(fillWhileDrain > 0, "R10", "fill ran ahead of pending drain beats", fillWhileDrain, 1);
    waitDrained();

    // R9: miss to the line still held in the buffer waits for the drain
    ackDelay = 3;
    miss(32'hC500_0000, 32'h0505_0505, 2'd1, 28'h123_4567, 1'b1, 1'b1);
    miss(32'h1234_5678, 32'h0606_0606, 2'd3, 28'h0AA_0001, 1'b0, 1'b1);
    chk(drainAddrQ.size() == 0, "R9", "same-line miss completed after drain", drainAddrQ.size(), 0);
    waitDrained();

    ackDelay = 0;
    repeat (5) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule